// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This unit works on two 64-bit operands that are viewed as a row of equal-width unsigned lanes. A lane-size input picks eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. An opcode picks one of six operations. Two are lane-wise additions: one wraps modulo the lane size and one clamps at the lane maximum. One is a lane-wise equality test that returns a full mask per lane. The other three are bitwise AND, AND-NOT and OR.

A typical use is image merging. An equality compare against a key colour produces a mask. AND-NOT with the foreground and AND with the background then keep the two parts, and an OR joins them. Each operation is accepted with `in_valid`. Its result is registered and presented together with `out_valid` on the next clock cycle.

Top module: `simd_packed_alu`

## Requirements
- R1: `lane_mode` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives a single 64-bit lane. Lane k occupies bits [k*w +: w].
- R2: Opcode 0 adds each pair of lanes modulo 2^w, for example byte 100 + 200 = 44 and 17 + 17 = 34. No carry passes from one lane into the next.
- R3: Opcode 1 adds each pair of lanes unsigned and clamps every lane whose sum exceeds 2^w−1 to 2^w−1, for example byte 100 + 200 = 255. A 64-bit lane clamps to all ones. Lanes that do not overflow give the plain sum.
- R4: Opcode 2 sets every bit of a lane to 1 when the two operand lanes are equal, and to 0 otherwise.
- R5: Opcode 3 gives a & b, opcode 4 gives ~a & b, and opcode 5 gives a | b, over all 64 bits and regardless of lane mode.
- R6: Opcodes 6 and 7 give a result of zero.
- R7: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. `result` carries the outcome of that accepted operation.
- R8: A synchronous active-high reset clears `out_valid` and `result` on the next clock edge.
- R9: While `in_valid` is low, `result` keeps its last value.
- R10: A compare mask followed by AND-NOT with a foreground, AND with a background, and OR of the two products yields (~mask & fg) | (mask & bg).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| lane_mode | input | 2 | Lane width select (R1) |
| opcode | input | 3 | Operation select |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Registered result |

## Verification
A broken carry chain at a lane boundary changes the lowest bit of the next lane up. A wrong saturation broadcast leaves part of a lane clamped and part wrapped. A mis-grouped compare gives a lane mask that is not uniform. Each of these shows up in the very next `result` that follows the request. A stale or wrongly enabled output register shows up in `out_valid` or in `result` on an idle cycle, one cycle after the cause. Because of this, every cycle is checked, including idle cycles and reset cycles, and the operands are chosen to sit on lane edges and overflow limits.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam logic [2:0] OP_ADDW  = 3'd0;
  localparam logic [2:0] OP_ADDS  = 3'd1;
  localparam logic [2:0] OP_CMPEQ = 3'd2;
  localparam logic [2:0] OP_AND   = 3'd3;
  localparam logic [2:0] OP_ANDN  = 3'd4;
  localparam logic [2:0] OP_OR    = 3'd5;

  // number of minimum-width units in one lane for a mode code, capped at the word
  function automatic int unit_per_lane(int mode_code, int n_units);
    int u;
    u = 1 << mode_code;
    if (u > n_units) u = n_units;
    return u;
  endfunction
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int DATA_W     = 64,
  parameter int LANE_MIN_W = 8,
  parameter int MODE_W     = 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] sum_wrap,
  output logic [DATA_W-1:0] sum_sat
);
  import simd_pkg::*;
  localparam int NU = DATA_W / LANE_MIN_W;

  logic [NU-1:0] unit_cout;
  logic [NU-1:0] unit_ovf;
  logic          chain;
  logic          cin;
  int            upl;
  int            top;

  always_comb begin
    sum_wrap  = '0;
    sum_sat   = '0;
    unit_cout = '0;
    unit_ovf  = '0;
    chain     = 1'b0;
    cin       = 1'b0;
    top       = 0;
    upl       = unit_per_lane(int'(mode), NU);
    // carry chain, cut at every lane start
    for (int i = 0; i < NU; i++) begin
      cin = ((i % upl) == 0) ? 1'b0 : chain;
      {unit_cout[i], sum_wrap[i*LANE_MIN_W +: LANE_MIN_W]} =
        {1'b0, a[i*LANE_MIN_W +: LANE_MIN_W]} +
        {1'b0, b[i*LANE_MIN_W +: LANE_MIN_W]} +
        {{LANE_MIN_W{1'b0}}, cin};
      chain = unit_cout[i];
    end
    // broadcast the carry out of each lane's top unit over the whole lane
    for (int i = 0; i < NU; i++) begin
      top = (i / upl) * upl + upl - 1;
      unit_ovf[i] = unit_cout[top];
      sum_sat[i*LANE_MIN_W +: LANE_MIN_W] =
        sum_wrap[i*LANE_MIN_W +: LANE_MIN_W] | {LANE_MIN_W{unit_ovf[i]}};
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int DATA_W     = 64,
  parameter int LANE_MIN_W = 8,
  parameter int MODE_W     = 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] mask
);
  import simd_pkg::*;
  localparam int NU = DATA_W / LANE_MIN_W;

  logic [NU-1:0] unit_eq;
  logic [NU-1:0] lane_eq;
  int            upl;

  generate
    for (genvar g = 0; g < NU; g++) begin : g_unit
      assign unit_eq[g] = (a[g*LANE_MIN_W +: LANE_MIN_W] == b[g*LANE_MIN_W +: LANE_MIN_W]);
    end
  endgenerate

  always_comb begin
    mask    = '0;
    lane_eq = '0;
    upl     = unit_per_lane(int'(mode), NU);
    for (int i = 0; i < NU; i++) begin
      lane_eq[i] = 1'b1;
      for (int j = 0; j < NU; j++) begin
        if ((j / upl) == (i / upl)) lane_eq[i] = lane_eq[i] & unit_eq[j];
      end
      mask[i*LANE_MIN_W +: LANE_MIN_W] = {LANE_MIN_W{lane_eq[i]}};
    end
  end
endmodule

// File: rtl/simd_packed_alu.sv
module simd_packed_alu #(
  parameter int DATA_W     = 64,
  parameter int LANE_MIN_W = 8,
  parameter int NU_P       = DATA_W / LANE_MIN_W,
  parameter int MODE_W     = $clog2($clog2(NU_P) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [MODE_W-1:0] lane_mode,
  input  logic [2:0]        opcode,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  import simd_pkg::*;
  localparam logic [MODE_W-1:0] MODE_WHOLE = MODE_W'($clog2(NU_P));

  logic [DATA_W-1:0] add_w;
  logic [DATA_W-1:0] add_s;
  logic [DATA_W-1:0] eq_mask;
  logic [DATA_W-1:0] nxt;

  simd_lane_adder #(.DATA_W(DATA_W), .LANE_MIN_W(LANE_MIN_W), .MODE_W(MODE_W)) u_add (
    .a(opa), .b(opb), .mode(lane_mode), .sum_wrap(add_w), .sum_sat(add_s)
  );

  simd_lane_cmp #(.DATA_W(DATA_W), .LANE_MIN_W(LANE_MIN_W), .MODE_W(MODE_W)) u_cmp (
    .a(opa), .b(opb), .mode(lane_mode), .mask(eq_mask)
  );

  always_comb begin
    case (opcode)
      OP_ADDW:  nxt = add_w;
      OP_ADDS:  nxt = add_s;
      OP_CMPEQ: nxt = eq_mask;
      OP_AND:   nxt = opa & opb;
      OP_ANDN:  nxt = ~opa & opb;
      OP_OR:    nxt = opa | opb;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R2
  wrap_whole_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_ADDW && lane_mode == MODE_WHOLE) |=> result == $past(opa + opb));
  // R4
  cmp_whole_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_CMPEQ && lane_mode == MODE_WHOLE) |=>
      result == ($past(opa == opb) ? {DATA_W{1'b1}} : {DATA_W{1'b0}}));
  // R5
  and_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_AND) |=> result == $past(opa & opb));
  // R6
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode > OP_OR) |=> result == '0);
endmodule

// File: tb/simd_packed_alu_test.sv
module simd_packed_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [1:0]  lane_mode = '0;
  logic [2:0]  opcode = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;

  always #10 clk = ~clk;

  simd_packed_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .lane_mode(lane_mode), .opcode(opcode), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic [2:0] op, logic [1:0] md);
    int lw;
    logic [64:0] m, x, y, s, v, acc;
    lw  = 8 << md;
    m   = (65'd1 << lw) - 65'd1;
    acc = '0;
    case (op)
      3'd3: return a & b;
      3'd4: return ~a & b;
      3'd5: return a | b;
      3'd0, 3'd1, 3'd2: begin
        for (int l = 0; l < 64 / lw; l++) begin
          x = ({1'b0, a} >> (l * lw)) & m;
          y = ({1'b0, b} >> (l * lw)) & m;
          s = x + y;
          if (op == 3'd0)      v = s & m;
          else if (op == 3'd1) v = (s > m) ? m : s;
          else                 v = (x == y) ? m : 65'd0;
          acc = acc | (v << (l * lw));
        end
        return acc[63:0];
      end
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send_exp(logic [63:0] a, logic [63:0] b, logic [2:0] op,
                          logic [1:0] md, logic [63:0] exp, string tag);
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; opcode = op; lane_mode = md;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic send(logic [63:0] a, logic [63:0] b, logic [2:0] op,
                      logic [1:0] md, string tag);
    send_exp(a, b, op, md, model(a, b, op, md), tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      opa = ~opa; opcode = 3'd5;
    end
  endtask

  // monitor: pops expected items as results appear
  initial begin
    logic v_exp, was_rst;
    forever begin
      @(posedge clk);
      v_exp   = in_valid && !rst;
      was_rst = rst;
      #5;
      if (was_rst) begin
        check(!out_valid && result == 64'd0, "R8 reset", result, 64'd0);
        last_exp = '0;
      end else begin
        check(out_valid == v_exp, "R7 out_valid", {63'd0, out_valid}, {63'd0, v_exp});
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected result", result, 64'd0);
          end else begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(result == e, t, result, e);
            last_exp = e;
          end
        end else begin
          check(result == last_exp, "R9 hold", result, last_exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] lf_a, lf_b;
    logic [63:0] mask, fg, bg, p1, p2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R2 byte wraparound and plain sums; R1 byte lanes
    send_exp({8'd5, 8'd6, 8'd7, 8'd8, 8'd9, 8'd100, 8'd87, 8'd17},
             {8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd200, 8'd13, 8'd17}, 3'd0, 2'd0,
             {8'd6, 8'd7, 8'd8, 8'd9, 8'd10, 8'd44, 8'd100, 8'd34}, "R2 byte wrap");
    // R3 byte saturation
    send_exp({8'd5, 8'd6, 8'd7, 8'd8, 8'd9, 8'd100, 8'd87, 8'd17},
             {8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd200, 8'd13, 8'd17}, 3'd1, 2'd0,
             {8'd6, 8'd7, 8'd8, 8'd9, 8'd10, 8'd255, 8'd100, 8'd34}, "R3 byte sat");
    // R2 no carry across 16-bit lanes; R1 mode 1
    send_exp(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 3'd0, 2'd1,
             64'h0000_0000_0000_0000, "R2 R1 half lanes no carry");
    // R3 16-bit saturation per lane, mixed
    send_exp(64'hFFFF_0001_8000_7FFF, 64'h0001_0001_8000_0001, 3'd1, 2'd1,
             64'hFFFF_0002_FFFF_8000, "R3 half lanes sat");
    // R2 R1 32-bit lanes
    send_exp(64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 3'd0, 2'd2,
             64'h0000_0000_0001_0000, "R2 R1 word lanes");
    // R3 64-bit lane clamps to all ones
    send_exp(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd1, 2'd3,
             64'hFFFF_FFFF_FFFF_FFFF, "R3 whole sat");
    send_exp(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 3'd0, 2'd3, 64'd0, "R2 whole wrap");
    // R4 byte compare
    send_exp({8'd15, 8'd15, 8'd100, 8'd120, 8'd101, 8'd76, 8'd15, 8'd15},
             64'h0F0F_0F0F_0F0F_0F0F, 3'd2, 2'd0,
             64'hFFFF_0000_0000_FFFF, "R4 byte cmp");
    // R4 one byte differing kills the whole 32-bit lane
    send_exp(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, 3'd2, 2'd2,
             64'hFFFF_FFFF_0000_0000, "R4 word cmp");
    // R5 bitwise ops
    send_exp(64'hF0F0_FF00_1234_0000, 64'h0FF0_F0F0_FFFF_1111, 3'd3, 2'd1,
             64'h00F0_F000_1234_0000, "R5 and");
    send_exp(64'hF0F0_FF00_1234_0000, 64'h0FF0_F0F0_FFFF_1111, 3'd4, 2'd0,
             64'h0F00_00F0_EDCB_1111, "R5 andn");
    send_exp(64'hF0F0_FF00_1234_0000, 64'h0FF0_F0F0_FFFF_1111, 3'd5, 2'd2,
             64'hFFF0_FFF0_FFFF_1111, "R5 or");
    // R6 unused opcodes
    send_exp(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 3'd6, 2'd0, 64'd0, "R6 code6");
    send_exp(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 3'd7, 2'd3, 64'd0, "R6 code7");
    idle(3);

    // R10 select chain
    mask = 64'hFFFF_0000_0000_FFFF;
    fg   = 64'h1111_2222_3333_4444;
    bg   = 64'hAAAA_BBBB_CCCC_DDDD;
    send_exp({8'd15, 8'd15, 8'd100, 8'd120, 8'd101, 8'd76, 8'd15, 8'd15},
             64'h0F0F_0F0F_0F0F_0F0F, 3'd2, 2'd0, mask, "R10 mask");
    p1 = 64'h0000_2222_3333_0000;
    p2 = 64'hAAAA_0000_0000_DDDD;
    send_exp(mask, fg, 3'd4, 2'd0, p1, "R10 fg part");
    send_exp(mask, bg, 3'd3, 2'd0, p2, "R10 bg part");
    send_exp(p1, p2, 3'd5, 2'd0, 64'hAAAA_2222_3333_DDDD, "R10 merged");
    idle(2);

    // R8 reset in mid-stream
    send(64'h55, 64'h66, 3'd0, 2'd0, "R8 pre-reset");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    void'(exp_q.pop_front());
    void'(tag_q.pop_front());
    idle(2);

    // R1 R2 R3 R4 R5 R6 mixed patterns with idle gaps
    lf_a = 64'h9E37_79B9_7F4A_7C15;
    lf_b = 64'hC2B2_AE3D_27D4_EB4F;
    for (int k = 0; k < 400; k++) begin
      lf_a = {lf_a[62:0], lf_a[63] ^ lf_a[62] ^ lf_a[60] ^ lf_a[59]};
      lf_b = {lf_b[62:0], lf_b[63] ^ lf_b[62] ^ lf_b[60] ^ lf_b[59]};
      if (k % 5 == 0)
        send(lf_a, (k % 10 == 0) ? lf_a : {lf_a[63:32], lf_b[31:0]},
             3'(k % 8), 2'(k / 8), "R1 R4 mixed");
      else
        send(lf_a, lf_b, 3'(k % 8), 2'(k / 8), "R1 R2 R3 R5 R6 mixed");
      if (k % 7 == 0) idle(1);
    end
    idle(3);
    check(exp_q.size() == 0, "R7 drained", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule